// File: doc/BRIEF.md
# Handheld LCD Video Capture

This block sits between the parallel colour bus of a handheld console's LCD panel and a line buffer in a video scaler. The panel interface has four signals: a 12-bit colour bus (4 bits each of red, green and blue), a slow pixel clock, an active-low vertical sync and a horizontal line strobe. There is no data-enable signal. The block oversamples all of them from a much faster system clock. It works out which samples are visible pixels, and it emits one write per visible pixel, with colour and x/y coordinates, in the system clock domain.

The control signals pass through two-flop synchronizers, and edges are detected on the synchronized copies. The colour bus is latched one system clock after a pixel-clock rising edge is detected. The active window is rebuilt from the sync edges and the pixel counts alone. A falling vertical sync opens a frame. Each line strobe opens a line. Up to `H_ACTIVE` pixels (160) are written per line, and up to `V_ACTIVE` lines (152) are written per frame. A sticky flag records any frame whose line count was wrong.

The controller has five states:
- **NOFRAME**: after reset, waiting for the first frame.
- **GAP**: inside a frame, waiting for a line strobe.
- **GRAB**: capturing pixels.
- **FULL**: the line is complete, so further pixels are dropped.
- **SKIP**: the line lies below the active window.

Transitions:
- **open_frame**: any state to GAP on a vertical sync fall.
- **open_line**: GAP, GRAB, FULL or SKIP to GRAB on a line strobe, while fewer than `V_ACTIVE` lines have begun.
- **overrun_line**: the same source states to SKIP on a line strobe otherwise.
- **line_full**: GRAB to FULL on the write of pixel `H_ACTIVE-1`.

Top module: `lcd_capture`

## Requirements
- R1: After reset, pix_we, sof_pulse, sol_pulse and frame_err are 0, and pix_x and pix_y are 0.
- R2: Before the first falling edge of lcd_vsync_n after reset, line strobes and pixel clocks produce no pix_we and no sol_pulse.
- R3: Each falling edge of lcd_vsync_n gives exactly one single-cycle sof_pulse and restarts line counting. A rising edge of lcd_vsync_n gives no pulse. No pix_we is high in the same cycle as sof_pulse.
- R4: Each rising edge of lcd_line inside a frame, for a line index below V_ACTIVE, gives one single-cycle sol_pulse and restarts the column count at 0. pix_y for that line equals the number of line strobes seen since the frame started, minus one.
- R5: Each rising edge of lcd_pclk during a line gives one write. pix_data holds the bus value, with bits 11:8 red, 7:4 green and 3:0 blue. pix_x counts 0, 1, 2, … in order.
- R6: At most H_ACTIVE (default 160) writes occur on one line. Further pixel clocks on that line are ignored.
- R7: Lines whose index is V_ACTIVE (default 152) or higher give no sol_pulse and no pix_we.
- R8: At a falling edge of lcd_vsync_n that closes a frame with a line strobe count other than V_ACTIVE, frame_err goes to 1. It stays 1 until reset. The first frame after reset closes nothing, so its opening edge never sets the flag.
- R9: pix_we is high for exactly one system clock per written pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcd_pclk | input | 1 | Panel pixel clock, asynchronous; the rising edge qualifies data |
| lcd_vsync_n | input | 1 | Active-low vertical sync, asynchronous |
| lcd_line | input | 1 | Horizontal line strobe, asynchronous; the rising edge starts a line |
| lcd_rgb | input | 12 | Colour bus: R in 11:8, G in 7:4, B in 3:0 |
| pix_data | output | 12 | Captured colour of the written pixel |
| pix_x | output | $clog2(H_ACTIVE) | Column of the written pixel |
| pix_y | output | $clog2(V_ACTIVE) | Row of the written pixel |
| pix_we | output | 1 | One-cycle write strobe for the line buffer |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| sol_pulse | output | 1 | One-cycle start-of-line pulse |
| frame_err | output | 1 | Sticky flag for a frame with a wrong line count |

## Verification
The bench goes after the edges of the rebuilt window:
- **Overlong line.** A design that fails to stop at the column limit would write past the line buffer.
- **Short line followed by a full one.** A design that forgets to clear the column on a strobe would start the next line at a non-zero x.
- **Frame with extra lines.** A design that fails to gate rows would keep writing below the window.
- **Frames that are too long or too short.** A design with a wrong or non-sticky error flag would miss the fault or clear it on the next good frame.

It also drives strobes and pixels before any vertical sync. A design that starts capturing straight out of reset would write garbage rows there.

// File: rtl/lcd_cap_pkg.sv
package lcd_cap_pkg;

    // Controller states of the capture engine
    typedef enum logic [2:0] {
        ST_NOFRAME = 3'd0,
        ST_GAP     = 3'd1,
        ST_GRAB    = 3'd2,
        ST_FULL    = 3'd3,
        ST_SKIP    = 3'd4
    } cap_state_t;

    // One panel pixel, 4 bits per primary
    typedef struct packed {
        logic [3:0] red;
        logic [3:0] green;
        logic [3:0] blue;
    } rgb444_t;

endpackage

// File: rtl/lcd_cap_sync.sv
module lcd_cap_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        logic hist_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
                hist_q <= RST_VAL[i];
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign level[i] = sync_q;
        assign rise[i]  = sync_q & ~hist_q;
        assign fall[i]  = ~sync_q & hist_q;
    end

endmodule

// File: rtl/lcd_cap_sampler.sv
module lcd_cap_sampler
    import lcd_cap_pkg::*;
#(
    parameter int C_W            = 12,
    parameter bit SAMPLE_ON_RISE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pclk_rise,
    input  logic           pclk_fall,
    input  logic [C_W-1:0] bus_rgb,
    output logic           smp_valid,
    output logic [C_W-1:0] smp_data
);

    logic edge_hit;
    logic edge_dly_q;

    // Choose which pixel-clock edge qualifies the bus
    if (SAMPLE_ON_RISE) begin : g_rise
        assign edge_hit = pclk_rise;
    end else begin : g_fall
        assign edge_hit = pclk_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_dly_q <= 1'b0;
            smp_valid  <= 1'b0;
            smp_data   <= '0;
        end else begin
            edge_dly_q <= edge_hit;
            smp_valid  <= edge_dly_q;
            if (edge_dly_q) begin
                smp_data <= bus_rgb;
            end
        end
    end

endmodule

// File: rtl/lcd_cap_fsm.sv
module lcd_cap_fsm
    import lcd_cap_pkg::*;
#(
    parameter int H_ACTIVE = 160,
    parameter int V_ACTIVE = 152,
    parameter int C_W      = 12,
    parameter int X_W      = $clog2(H_ACTIVE),
    parameter int Y_W      = $clog2(V_ACTIVE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           line_start,
    input  logic           smp_valid,
    input  logic [C_W-1:0] smp_data,
    output logic [C_W-1:0] pix_data,
    output logic [X_W-1:0] pix_x,
    output logic [Y_W-1:0] pix_y,
    output logic           pix_we,
    output logic           sof_pulse,
    output logic           sol_pulse,
    output logic           frame_err
);

    localparam int              LC_W   = $clog2(V_ACTIVE + 2) + 1;
    localparam logic [LC_W-1:0] V_LIM  = LC_W'(V_ACTIVE);
    localparam logic [LC_W-1:0] LC_MAX = '1;
    localparam logic [X_W-1:0]  X_LAST = X_W'(H_ACTIVE - 1);

    cap_state_t      state_q;
    cap_state_t      state_nx;
    logic [X_W-1:0]  x_cnt_q;
    logic [LC_W-1:0] line_cnt_q;
    logic            frame_open_q;
    logic            take_pix;

    assign take_pix = smp_valid && (state_q == ST_GRAB);

    // Next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_NOFRAME: begin
                if (frame_start) state_nx = ST_GAP;
            end
            ST_GAP, ST_FULL, ST_SKIP: begin
                if (frame_start)          state_nx = ST_GAP;
                else if (line_start)      state_nx = (line_cnt_q < V_LIM) ? ST_GRAB : ST_SKIP;
            end
            ST_GRAB: begin
                if (frame_start)          state_nx = ST_GAP;
                else if (line_start)      state_nx = (line_cnt_q < V_LIM) ? ST_GRAB : ST_SKIP;
                else if (take_pix && x_cnt_q == X_LAST) state_nx = ST_FULL;
            end
            default: state_nx = ST_NOFRAME;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NOFRAME;
        end else begin
            state_q <= state_nx;
        end
    end

    // Counters, flags and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_data     <= '0;
            pix_x        <= '0;
            pix_y        <= '0;
            pix_we       <= 1'b0;
            sof_pulse    <= 1'b0;
            sol_pulse    <= 1'b0;
            frame_err    <= 1'b0;
            x_cnt_q      <= '0;
            line_cnt_q   <= '0;
            frame_open_q <= 1'b0;
        end else begin
            pix_we    <= 1'b0;
            sof_pulse <= 1'b0;
            sol_pulse <= 1'b0;
            if (frame_start) begin
                sof_pulse    <= 1'b1;
                frame_open_q <= 1'b1;
                if (frame_open_q && line_cnt_q != V_LIM) begin
                    frame_err <= 1'b1;
                end
                line_cnt_q <= '0;
                x_cnt_q    <= '0;
            end else if (line_start && state_q != ST_NOFRAME) begin
                x_cnt_q <= '0;
                if (line_cnt_q < V_LIM) begin
                    sol_pulse <= 1'b1;
                    pix_y     <= Y_W'(line_cnt_q);
                end
                if (line_cnt_q != LC_MAX) begin
                    line_cnt_q <= line_cnt_q + 1'b1;
                end
            end else if (take_pix) begin
                pix_we   <= 1'b1;
                pix_data <= smp_data;
                pix_x    <= x_cnt_q;
                x_cnt_q  <= x_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_capture.sv
module lcd_capture
    import lcd_cap_pkg::*;
#(
    parameter  int H_ACTIVE = 160,
    parameter  int V_ACTIVE = 152,
    parameter  int C_W      = 12,
    localparam int X_W      = $clog2(H_ACTIVE),
    localparam int Y_W      = $clog2(V_ACTIVE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lcd_pclk,
    input  logic           lcd_vsync_n,
    input  logic           lcd_line,
    input  logic [C_W-1:0] lcd_rgb,
    output logic [C_W-1:0] pix_data,
    output logic [X_W-1:0] pix_x,
    output logic [Y_W-1:0] pix_y,
    output logic           pix_we,
    output logic           sof_pulse,
    output logic           sol_pulse,
    output logic           frame_err
);

    // Bit order of the synchronized control bundle
    localparam int BIT_PCLK  = 0;
    localparam int BIT_VSYNC = 1;
    localparam int BIT_LINE  = 2;

    logic [2:0]     ctl_raw;
    logic [2:0]     ctl_lvl;
    logic [2:0]     ctl_rise;
    logic [2:0]     ctl_fall;
    logic           smp_valid;
    logic [C_W-1:0] smp_data;

    assign ctl_raw = {lcd_line, lcd_vsync_n, lcd_pclk};

    lcd_cap_sync #(
        .N       (3),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_raw),
        .level    (ctl_lvl),
        .rise     (ctl_rise),
        .fall     (ctl_fall)
    );

    lcd_cap_sampler #(
        .C_W            (C_W),
        .SAMPLE_ON_RISE (1'b1)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .pclk_rise (ctl_rise[BIT_PCLK]),
        .pclk_fall (ctl_fall[BIT_PCLK]),
        .bus_rgb   (lcd_rgb),
        .smp_valid (smp_valid),
        .smp_data  (smp_data)
    );

    lcd_cap_fsm #(
        .H_ACTIVE (H_ACTIVE),
        .V_ACTIVE (V_ACTIVE),
        .C_W      (C_W),
        .X_W      (X_W),
        .Y_W      (Y_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (ctl_fall[BIT_VSYNC]),
        .line_start  (ctl_rise[BIT_LINE]),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .pix_data    (pix_data),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .pix_we      (pix_we),
        .sof_pulse   (sof_pulse),
        .sol_pulse   (sol_pulse),
        .frame_err   (frame_err)
    );

    // Levels are kept for observation only; edges drive the logic
    logic unused_lvl;
    assign unused_lvl = ^{ctl_lvl, ctl_rise[BIT_PCLK], ctl_fall[BIT_LINE],
                          ctl_rise[BIT_VSYNC]};

endmodule

// File: rtl/lcd_capture_chk.sv
module lcd_capture_chk #(
    parameter  int H_ACTIVE = 160,
    parameter  int V_ACTIVE = 152,
    localparam int X_W      = $clog2(H_ACTIVE),
    localparam int Y_W      = $clog2(V_ACTIVE)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [X_W-1:0] pix_x,
    input logic [Y_W-1:0] pix_y,
    input logic           pix_we,
    input logic           sof_pulse,
    input logic           sol_pulse,
    input logic           frame_err
);

    localparam logic [X_W-1:0] X_LIM = X_W'(H_ACTIVE - 1);
    localparam logic [Y_W-1:0] Y_LIM = Y_W'(V_ACTIVE - 1);

    // Column the next write must carry
    logic [X_W-1:0] exp_x_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_x_q <= '0;
        end else if (sol_pulse) begin
            exp_x_q <= '0;
        end else if (pix_we) begin
            exp_x_q <= pix_x + 1'b1;
        end
    end

    p_col_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> pix_x <= X_LIM);

    p_row_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> pix_y <= Y_LIM);

    p_col_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> pix_x == exp_x_q);

    p_we_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |=> !pix_we);

    p_sof_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse);

    p_sof_no_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> !pix_we);

    p_sol_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sol_pulse |=> !sol_pulse);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    p_err_at_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> sof_pulse);

endmodule

bind lcd_capture lcd_capture_chk #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_we    (pix_we),
    .sof_pulse (sof_pulse),
    .sol_pulse (sol_pulse),
    .frame_err (frame_err)
);

// File: tb/test_lcd_capture.sv
module test_lcd_capture;

    localparam int CLK_PERIOD = 10;
    localparam int H   = 20;
    localparam int V   = 10;
    localparam int XW  = $clog2(H);
    localparam int YW  = $clog2(V);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lcd_pclk = 1'b0;
    logic          lcd_vsync_n = 1'b1;
    logic          lcd_line = 1'b0;
    logic [11:0]   lcd_rgb = '0;
    logic [11:0]   pix_data;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;
    logic          pix_we;
    logic          sof_pulse;
    logic          sol_pulse;
    logic          frame_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int wr_total, sol_cnt, sof_cnt, mon_bad, next_x;
    int line_wr [V];
    logic prev_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_capture #(.H_ACTIVE(H), .V_ACTIVE(V), .C_W(12)) i_lcd_capture (
        .clk(clk), .rst_n(rst_n), .lcd_pclk(lcd_pclk), .lcd_vsync_n(lcd_vsync_n),
        .lcd_line(lcd_line), .lcd_rgb(lcd_rgb), .pix_data(pix_data), .pix_x(pix_x),
        .pix_y(pix_y), .pix_we(pix_we), .sof_pulse(sof_pulse), .sol_pulse(sol_pulse),
        .frame_err(frame_err)
    );

    function automatic logic [11:0] colour(int y, int x);
        return 12'((y * 64) + x) ^ 12'h9C3;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_we) begin
                wr_total++;
                if (int'(pix_x) >= H || int'(pix_y) >= V ||
                    pix_data != colour(int'(pix_y), int'(pix_x)) ||
                    int'(pix_x) != next_x || prev_we) begin
                    mon_bad++;
                end else begin
                    line_wr[int'(pix_y)]++;
                end
                next_x = int'(pix_x) + 1;
            end
            if (sol_pulse) begin
                sol_cnt++;
                next_x = 0;
            end
            if (sof_pulse) sof_cnt++;
            prev_we = pix_we;
        end else begin
            prev_we = 1'b0;
        end
    end

    task automatic clear_mon();
        @(negedge clk);
        wr_total = 0; sol_cnt = 0; sof_cnt = 0; mon_bad = 0; next_x = 0;
        for (int i = 0; i < V; i++) line_wr[i] = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lcd_pclk = 1'b0; lcd_vsync_n = 1'b1; lcd_line = 1'b0; lcd_rgb = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic vsync_pulse();
        @(negedge clk);
        lcd_vsync_n = 1'b0;
        repeat (6) @(negedge clk);
        lcd_vsync_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_line(int y, int npix);
        @(negedge clk);
        lcd_line = 1'b1;
        repeat (4) @(negedge clk);
        lcd_line = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < npix; i++) begin
            lcd_rgb  = colour(y, i);
            lcd_pclk = 1'b0;
            repeat (4) @(negedge clk);
            lcd_pclk = 1'b1;
            repeat (5) @(negedge clk);
        end
        lcd_pclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(!pix_we && !sof_pulse && !sol_pulse && !frame_err && pix_x == '0 && pix_y == '0,
              "R1 reset outputs", int'({pix_we, sof_pulse, sol_pulse, frame_err}), 0);
    endtask

    task automatic t_before_frame();
        clear_mon();
        send_line(0, H);
        send_line(1, H);
        check(wr_total == 0, "R2 writes before first frame", wr_total, 0);
        check(sol_cnt == 0, "R2 line pulses before first frame", sol_cnt, 0);
    endtask

    task automatic t_normal_frame();
        int bad_rows = 0;
        clear_mon();
        vsync_pulse();
        check(frame_err == 1'b0, "R8 first frame opening sets no error", int'(frame_err), 0);
        for (int y = 0; y < V; y++) send_line(y, H);
        vsync_pulse();
        check(sof_cnt == 2, "R3 one sof per vsync fall", sof_cnt, 2);
        check(sol_cnt == V, "R4 one sol per line", sol_cnt, V);
        check(wr_total == H * V, "R5 write count full frame", wr_total, H * V);
        check(mon_bad == 0, "R5/R9 data, column order, single-cycle strobe", mon_bad, 0);
        for (int y = 0; y < V; y++) if (line_wr[y] != H) bad_rows++;
        check(bad_rows == 0, "R4 every row index gets its pixels", bad_rows, 0);
        check(frame_err == 1'b0, "R8 good frame no error", int'(frame_err), 0);
    endtask

    task automatic t_line_lengths();
        clear_mon();
        send_line(0, H + 4);
        send_line(1, H - 7);
        for (int y = 2; y < V; y++) send_line(y, H);
        check(line_wr[0] == H, "R6 overlong line capped", line_wr[0], H);
        check(line_wr[1] == H - 7, "R4 short line count", line_wr[1], H - 7);
        check(line_wr[2] == H, "R4 column restarts after short line", line_wr[2], H);
        check(mon_bad == 0, "R5 data and order across odd lengths", mon_bad, 0);
        vsync_pulse();
        check(frame_err == 1'b0, "R8 odd line lengths no error", int'(frame_err), 0);
    endtask

    task automatic t_extra_lines();
        clear_mon();
        for (int y = 0; y < V + 2; y++) send_line(y, H);
        check(sol_cnt == V, "R7 no sol below window", sol_cnt, V);
        check(wr_total == H * V, "R7 no writes below window", wr_total, H * V);
        check(mon_bad == 0, "R7 rows stay in window", mon_bad, 0);
        check(frame_err == 1'b0, "R8 flag waits for frame end", int'(frame_err), 0);
        vsync_pulse();
        check(frame_err == 1'b1, "R8 long frame flagged", int'(frame_err), 1);
        for (int y = 0; y < V; y++) send_line(y, H);
        vsync_pulse();
        check(frame_err == 1'b1, "R8 flag sticky over good frame", int'(frame_err), 1);
    endtask

    task automatic t_short_frame();
        do_reset();
        check(frame_err == 1'b0, "R1 reset clears flag", int'(frame_err), 0);
        vsync_pulse();
        for (int y = 0; y < V - 1; y++) send_line(y, H);
        vsync_pulse();
        check(frame_err == 1'b1, "R8 short frame flagged", int'(frame_err), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_before_frame();
        t_normal_frame();
        t_line_lengths();
        t_extra_lines();
        t_short_frame();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule